// File: doc/BRIEF.md
# Protecting-Distance Set Replacement Controller

This block runs the replacement policy for one set of a W-way last-level cache. Each way keeps three things: a valid bit, a reused flag, and a small counter holding the line's remaining protection. A line with a nonzero counter is protected and is not evicted while an unprotected line is available. Whenever a line is filled or hit, its counter is reloaded from the protecting distance supplied from outside. The counters of the other lines count down as the set is accessed.

The counters are only a few bits wide, and the distance can be as large as 255. The block therefore scales the distance. A prescaler counts accesses to the set and issues one decrement tick every `(pd >> RPD_W) + 1` accesses. A refreshed line is loaded with `pd / ((pd >> RPD_W) + 1)`, which always fits in the counter.

On a miss the block names a victim way. Invalid ways come first, then expired lines. When every line is still protected, the outcome depends on the mode. In bypass mode the fill is refused. Otherwise the block falls back to the most-protected line that has never been reused, and only then to the most-protected line of any kind.

Top module: `pdp_set_ctrl`

## Requirements
- R1: After reset every way is invalid, with reused flag 0 and counter 0, and `bypass` is low.
- R2: A hit on way h, or an insertion into way v, loads that way's counter with `pd / ((pd >> RPD_W) + 1)`, using the `pd` present on that access.
- R3: A prescaler counts accesses from 0 after reset. The access on which the count reaches `(pd >> RPD_W)` or more is a tick, and the count then restarts at 0. On a tick, every way not loaded on that access decrements its counter, saturating at 0 and never wrapping. Without a tick, unloaded counters keep their value.
- R4: A hit sets the hit way's reused flag. An insertion sets the victim's valid bit and clears its reused flag.
- R5: On a miss with any invalid way present, `victim_way` is the lowest-numbered invalid way.
- R6: On a miss with all ways valid and at least one counter at 0, `victim_way` is the lowest-numbered way whose counter is 0.
- R7: On a miss with every counter nonzero and `bypass_en` low, `victim_way` is the way with the highest counter among ways whose reused flag is 0. The lowest number wins a tie.
- R8: When R7 applies but every way has its reused flag set, `victim_way` is the way with the highest counter overall. The lowest number wins a tie.
- R9: On a miss with all ways valid, every counter nonzero and `bypass_en` high, `bypass` is high. No way is filled, and only the R3 decrements change state.
- R10: `bypass` is low on every hit and on every cycle without an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| access | input | 1 | The set is accessed this cycle |
| hit | input | 1 | The access hits |
| hit_way | input | IDX_W | Way that hits |
| pd | input | PD_W | Current protecting distance |
| bypass_en | input | 1 | Refuse fills when every line is protected |
| victim_way | output | IDX_W | Way chosen for replacement |
| bypass | output | 1 | The miss is not filled |
| way_valid | output | WAYS | Valid bit per way |
| way_reused | output | WAYS | Reused flag per way |
| way_rpd | output | WAYS*RPD_W | Remaining-protection counters, way 0 in the low bits |

## Verification
Several properties are checked every cycle by the assertions:
- a counter moves down by at most one step and never wraps out of zero;
- a loaded way holds the scaled distance on the next cycle;
- an insertion clears the reused flag;
- the prescaler restarts after a tick;
- whenever a free or expired way exists, the chosen victim is free or expired;
- a bypass never coincides with a hit.

Other behaviour needs the bench's reference model and sequences of accesses:
- the exact ordering among protected lines;
- tie-breaking toward the lowest way;
- the tick spacing for large distances;
- the decrement pattern after a bypass.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
  // number of set accesses per counter decrement
  function automatic int unsigned pd_step(input int unsigned pd, input int unsigned bits);
    return (pd >> bits) + 1;
  endfunction

  // counter value loaded on fill or hit; always below 2**bits
  function automatic int unsigned pd_load(input int unsigned pd, input int unsigned bits);
    return pd / pd_step(pd, bits);
  endfunction
endpackage

// File: rtl/pdp_prescaler.sv
module pdp_prescaler #(
  parameter int PD_W  = 8,
  parameter int RPD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             access,
  input  logic [PD_W-1:0]  pd,
  output logic             tick,
  output logic [RPD_W-1:0] load_val
);
  import pdp_pkg::*;
  logic [PD_W-1:0] cnt;
  logic [PD_W-1:0] step_m1;

  always_comb begin
    step_m1  = PD_W'(pd_step(int'(pd), RPD_W) - 1);
    load_val = RPD_W'(pd_load(int'(pd), RPD_W));
    tick     = access && (cnt >= step_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (access) cnt <= tick ? '0 : cnt + 1'b1;
  end

  // R3
  restart_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == '0);
endmodule

// File: rtl/pdp_way_state.sv
module pdp_way_state #(
  parameter int RPD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             insert,
  input  logic             hit_set,
  input  logic             tick,
  input  logic [RPD_W-1:0] load_val,
  output logic             valid,
  output logic             reused,
  output logic [RPD_W-1:0] rpd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      reused <= 1'b0;
      rpd    <= '0;
    end else if (load) begin
      rpd <= load_val;
      if (insert) begin
        valid  <= 1'b1;
        reused <= 1'b0;
      end
      if (hit_set) reused <= 1'b1;
    end else if (tick && rpd != '0) begin
      rpd <= rpd - 1'b1;
    end
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rpd == $past(load_val));
  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && rpd == '0) |=> rpd == '0);
  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (rpd == $past(rpd) || rpd == $past(rpd) - 1'b1));
  // R4
  insert_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insert |=> (valid && !reused));
endmodule

// File: rtl/pdp_victim_sel.sv
module pdp_victim_sel #(
  parameter int WAYS  = 4,
  parameter int RPD_W = 3,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       miss,
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0]            reused,
  input  logic [WAYS-1:0][RPD_W-1:0] rpd,
  output logic [IDX_W-1:0]           victim,
  output logic                       all_prot
);
  logic             inv_found, zero_found, nr_found;
  logic [IDX_W-1:0] inv_idx, zero_idx, nr_idx, top_idx;
  logic [RPD_W-1:0] nr_max, top_max;

  always_comb begin
    inv_found = 1'b0; inv_idx  = '0;
    zero_found = 1'b0; zero_idx = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        inv_found = 1'b1;
        inv_idx   = IDX_W'(i);
      end
      if (rpd[i] == '0) begin
        zero_found = 1'b1;
        zero_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    nr_found = 1'b0; nr_idx = '0; nr_max = '0;
    top_idx = '0; top_max = rpd[0];
    for (int i = 0; i < WAYS; i++) begin
      if (!reused[i] && (!nr_found || rpd[i] > nr_max)) begin
        nr_found = 1'b1;
        nr_idx   = IDX_W'(i);
        nr_max   = rpd[i];
      end
      if (rpd[i] > top_max) begin
        top_idx = IDX_W'(i);
        top_max = rpd[i];
      end
    end
  end

  always_comb begin
    all_prot = !inv_found && !zero_found;
    if (inv_found)       victim = inv_idx;
    else if (zero_found) victim = zero_idx;
    else if (nr_found)   victim = nr_idx;
    else                 victim = top_idx;
  end

  // R5 R6
  free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !all_prot) |-> (!valid[victim] || rpd[victim] == '0));
  // R7
  unreused_pref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && all_prot && (reused != {WAYS{1'b1}})) |-> !reused[victim]);
endmodule

// File: rtl/pdp_set_ctrl.sv
module pdp_set_ctrl #(
  parameter int WAYS  = 4,
  parameter int RPD_W = 3,
  parameter int PD_W  = 8,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    access,
  input  logic                    hit,
  input  logic [IDX_W-1:0]        hit_way,
  input  logic [PD_W-1:0]         pd,
  input  logic                    bypass_en,
  output logic [IDX_W-1:0]        victim_way,
  output logic                    bypass,
  output logic [WAYS-1:0]         way_valid,
  output logic [WAYS-1:0]         way_reused,
  output logic [WAYS*RPD_W-1:0]   way_rpd
);
  logic                       tick;
  logic [RPD_W-1:0]           load_val;
  logic [WAYS-1:0][RPD_W-1:0] rpd_q;
  logic                       miss, all_prot, fill;
  logic [WAYS-1:0]            hit_ld, ins_ld;

  assign miss   = access && !hit;
  assign bypass = miss && all_prot && bypass_en;
  assign fill   = miss && !bypass;
  assign way_rpd = rpd_q;

  pdp_prescaler #(.PD_W(PD_W), .RPD_W(RPD_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .access(access), .pd(pd),
    .tick(tick), .load_val(load_val));

  pdp_victim_sel #(.WAYS(WAYS), .RPD_W(RPD_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .miss(miss), .valid(way_valid),
    .reused(way_reused), .rpd(rpd_q), .victim(victim_way), .all_prot(all_prot));

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_ld[w] = access && hit && (hit_way == IDX_W'(w));
    assign ins_ld[w] = fill && (victim_way == IDX_W'(w));
    pdp_way_state #(.RPD_W(RPD_W)) u_way (
      .clk(clk), .rst_n(rst_n), .load(hit_ld[w] || ins_ld[w]),
      .insert(ins_ld[w]), .hit_set(hit_ld[w]), .tick(tick),
      .load_val(load_val), .valid(way_valid[w]),
      .reused(way_reused[w]), .rpd(rpd_q[w]));
  end

  // R10
  bypass_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (access && !hit));
  // R9
  bypass_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> way_valid == $past(way_valid) && way_reused == $past(way_reused));
endmodule

// File: tb/test_pdp_set_ctrl.sv
module test_pdp_set_ctrl;
  localparam int W = 4, B = 3, P = 8;
  logic clk = 0, rst_n = 0, access = 0, hit = 0, bypass_en = 0;
  logic [1:0] hit_way = 0;
  logic [P-1:0] pd = 0;
  logic [1:0] victim_way;
  logic bypass;
  logic [W-1:0] way_valid, way_reused;
  logic [W*B-1:0] way_rpd;

  int checks = 0, fails = 0;
  bit m_valid [W];
  bit m_reused [W];
  int m_rpd [W];
  int m_cnt;

  always #4 clk = ~clk;

  pdp_set_ctrl #(.WAYS(W), .RPD_W(B), .PD_W(P)) i_pdp_set_ctrl (
    .clk(clk), .rst_n(rst_n), .access(access), .hit(hit), .hit_way(hit_way),
    .pd(pd), .bypass_en(bypass_en), .victim_way(victim_way), .bypass(bypass),
    .way_valid(way_valid), .way_reused(way_reused), .way_rpd(way_rpd));

  function automatic int ticks_per(int d); return d / (1 << B) + 1; endfunction
  function automatic int scaled(int d); return d / ticks_per(d); endfunction

  function automatic int exp_victim();
    int best;
    best = -1;
    for (int i = 0; i < W; i++) if (!m_valid[i]) return i;
    for (int i = 0; i < W; i++) if (m_rpd[i] == 0) return i;
    for (int i = 0; i < W; i++)
      if (!m_reused[i] && (best < 0 || m_rpd[i] > m_rpd[best])) best = i;
    if (best >= 0) return best;
    best = 0;
    for (int i = 1; i < W; i++) if (m_rpd[i] > m_rpd[best]) best = i;
    return best;
  endfunction

  function automatic bit exp_protected();
    for (int i = 0; i < W; i++) if (!m_valid[i] || m_rpd[i] == 0) return 0;
    return 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    for (int i = 0; i < W; i++) begin
      check(way_valid[i] == m_valid[i], {req, " valid"}, way_valid[i], m_valid[i]);
      check(way_reused[i] == m_reused[i], {req, " reused"}, way_reused[i], m_reused[i]);
      check(int'(way_rpd[i*B +: B]) == m_rpd[i], {req, " rpd"}, int'(way_rpd[i*B +: B]), m_rpd[i]);
    end
  endtask

  task automatic do_access(input bit h, input int hw, input int d, input bit be);
    int v, ld;
    bit byp, tk;
    @(negedge clk);
    access = 1; hit = h; hit_way = 2'(hw); pd = P'(d); bypass_en = be;
    #1;
    v = exp_victim();
    byp = !h && be && exp_protected();
    check(bypass == byp, "R9/R10 bypass", bypass, byp);
    if (!h && !byp) begin
      if (!m_valid[v]) check(int'(victim_way) == v, "R5 victim", victim_way, v);
      else if (m_rpd[v] == 0) check(int'(victim_way) == v, "R6 victim", victim_way, v);
      else check(int'(victim_way) == v, "R7_R8 victim", victim_way, v);
    end
    tk = m_cnt >= ticks_per(d) - 1;
    m_cnt = tk ? 0 : m_cnt + 1;
    ld = h ? hw : (byp ? -1 : v);
    for (int i = 0; i < W; i++) begin
      if (i == ld) begin
        m_rpd[i] = scaled(d);
        if (h) m_reused[i] = 1;
        else begin m_valid[i] = 1; m_reused[i] = 0; end
      end else if (tk && m_rpd[i] > 0) m_rpd[i]--;
    end
    @(negedge clk);
    access = 0;
    #1;
    check(bypass == 0, "R10 idle", bypass, 0);
    check_state(h ? "R2_R3_R4 hit" : (byp ? "R9 bypass" : "R2_R3_R4 fill"));
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int hw, n;
    void'($urandom(32'd1234));
    for (int i = 0; i < W; i++) begin m_valid[i] = 0; m_reused[i] = 0; m_rpd[i] = 0; end
    m_cnt = 0;
    repeat (3) @(posedge clk);
    #1;
    check(bypass == 0, "R1 bypass", bypass, 0);
    check_state("R1 reset");
    rst_n = 1;
    // directed: fill with pd=7 -> step 1, load 7; then all protected
    for (int i = 0; i < W; i++) do_access(0, 0, 7, 0);
    do_access(0, 0, 7, 1);     // R9 bypass
    do_access(0, 0, 7, 0);     // R7 highest unreused
    for (int i = 0; i < W; i++) do_access(1, i, 7, 0);
    do_access(0, 0, 7, 0);     // R8 all reused
    // large distance: step 32, load 7
    for (int i = 0; i < 70; i++) do_access(1, i % W, 255, 0);
    // pd 0 -> expired lines, R6
    do_access(1, 2, 0, 0);
    do_access(0, 0, 0, 0);
    // random mix
    for (int k = 0; k < 600; k++) begin
      n = $urandom_range(0, 3);
      hw = $urandom_range(0, W - 1);
      if (n == 0 || !m_valid[hw])
        do_access(0, 0, (k % 5 == 0) ? $urandom_range(0, 255) : $urandom_range(0, 20), $urandom_range(0, 1));
      else
        do_access(1, hw, $urandom_range(0, 40), $urandom_range(0, 1));
    end
    // reset again mid-run, R1
    @(negedge clk); rst_n = 0; #1;
    for (int i = 0; i < W; i++) begin m_valid[i] = 0; m_reused[i] = 0; m_rpd[i] = 0; end
    m_cnt = 0;
    check_state("R1 reset again");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule